// File: doc/BRIEF.md
# IR Run-Length Receive Sampler

This block takes a demodulated infrared receiver signal and samples it on a fixed tick. Each stretch of constant level becomes one byte. The top bit of the byte says whether the stretch was a pulse or a space. The low seven bits hold its length in ticks, minus one. The bytes are queued in a small FIFO and leave the block as a valid/ready byte stream.

A sticky overrun flag and an interrupt request report on the state of the queue. The overrun flag marks codes that were lost. The interrupt request is raised while the queue is at least half full.

The tick is derived from the system clock in two stages. A fixed prescaler comes first. It is followed by one of two divisors: a coarse one for normal timing and a fine one for high-resolution capture. An idle command stops capture and throws away the run in progress. The receiver then stays silent until a tick sees pulse level again. A polarity input serves receivers whose output is active low.

Stream rules: `code_valid` is high exactly while the queue is non-empty. `code_data` shows the oldest code. A code is consumed on a clock edge where both `code_valid` and `code_ready` are high. While `code_ready` is low, the code on offer does not change. There is no back-pressure toward the infrared input. When the queue is full, a newly finished run is lost and is reported through `overrun`.

Top module: `ir_rle_rx`

## Requirements
- R1: Each code is 8 bits. Bit 7 is 1 for a space and 0 for a pulse. Bits 6:0 hold the run length in ticks minus one, so a run of N ticks (1 to 128) is coded as N-1.
- R2: The tick period is PRESCALE*DIV_NORM clock cycles when `fine_res` is 0, and PRESCALE*DIV_HIRES cycles when it is 1. Run lengths are counted in these ticks.
- R3: With `ir_invert` = 1, a low `ir_in` is taken as pulse level. With `ir_invert` = 0, a high `ir_in` is pulse level.
- R4: Codes leave in the order the runs ended. While `code_valid` is high and `code_ready` is low, `code_valid` stays high and `code_data` stays unchanged.
- R5: The queue holds DEPTH (16) codes. `irq` is high exactly while it holds at least IRQ_LEVEL (8) codes, so it is 0 with 7 codes and 1 with 8.
- R6: A run longer than 128 ticks is emitted as a series of codes of the same level. Each full piece is 128 ticks (0x7F for a pulse, 0xFF for a space), and the remainder forms the final code. A run of exactly 128 ticks gives a single code.
- R7: A code that finishes while the queue is full and not being read is dropped, and `overrun` is set. `overrun` stays set until a cycle with `stat_rd` high, after which it reads 0. If a drop and `stat_rd` fall in the same cycle, `overrun` stays set.
- R8: A pulse on `idle_cmd` discards the run in progress without emitting it. After that, spaces produce no codes until a tick samples pulse level, which starts a new run of 1 tick.
- R9: After reset the receiver is idle, and `code_valid`, `irq` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated infrared receiver signal (asynchronous) |
| ir_invert | input | 1 | 1: low level on `ir_in` is pulse |
| fine_res | input | 1 | 1: high-resolution tick (fine divisor) |
| idle_cmd | input | 1 | Stop capture and drop the current run |
| stat_rd | input | 1 | Status read strobe; clears `overrun` |
| code_valid | output | 1 | A code is available |
| code_ready | input | 1 | Consumer accepts the code on offer |
| code_data | output | 8 | Oldest run-length code |
| overrun | output | 1 | Sticky flag: a code was dropped |
| irq | output | 1 | Queue at or above the interrupt level |

## Verification
The two functions that can collide in one cycle are the setting of `overrun` by a dropped code and its clearing by a status read. The queue is filled past capacity with one-tick runs and `code_ready` held low. `stat_rd` is then held high across several more level changes, each of which drops a code. The check passes when `overrun` is seen high during that window: if the read took priority, the flag would never become visible while `stat_rd` stays asserted. After the toggling stops, a single status read must clear the flag, and the 16 queued codes must come out in arrival order.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
  localparam int unsigned LEN_W  = 7;
  localparam int unsigned CODE_W = LEN_W + 1;

  typedef struct packed {
    logic             is_space;
    logic [LEN_W-1:0] len_m1;
  } run_code_t;

  typedef enum logic {
    RX_IDLE    = 1'b0,
    RX_CAPTURE = 1'b1
  } rx_state_e;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int unsigned PRESCALE  = 16,
  parameter int unsigned DIV_NORM  = 15,
  parameter int unsigned DIV_HIRES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fine_res,
  output logic tick
);
  localparam int unsigned DIV_TOP = (DIV_NORM > DIV_HIRES) ? DIV_NORM : DIV_HIRES;
  localparam int unsigned DIV_W   = (DIV_TOP > 1) ? $clog2(DIV_TOP) : 1;
  localparam logic [DIV_W-1:0] LIM_NORM = DIV_W'(DIV_NORM - 1);
  localparam logic [DIV_W-1:0] LIM_FINE = DIV_W'(DIV_HIRES - 1);

  logic             base_tick;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_lim;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int unsigned PRE_W = $clog2(PRESCALE);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
      logic [PRE_W-1:0] pre_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pre_cnt <= '0;
        else if (pre_cnt == PRE_LAST) pre_cnt <= '0;
        else                        pre_cnt <= pre_cnt + 1'b1;
      end
      assign base_tick = (pre_cnt == PRE_LAST);
    end else begin : g_nopre
      assign base_tick = 1'b1;
    end
  endgenerate

  // A counter left above a smaller limit after a mode change wraps at once.
  assign div_lim = fine_res ? LIM_FINE : LIM_NORM;
  assign tick    = base_tick && (div_cnt >= div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_cnt <= '0;
    else if (base_tick) div_cnt <= tick ? '0 : div_cnt + 1'b1;
  end
endmodule

// File: rtl/ir_run_encoder.sv
module ir_run_encoder
  import ir_rle_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      lvl_pulse,
  input  logic      idle_cmd,
  output logic      emit,
  output run_code_t code
);
  localparam logic [LEN_W-1:0] CNT_TOP = '1;

  rx_state_e        state;
  logic             cur_pulse;
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cur_pulse <= 1'b0;
      cnt       <= '0;
      emit      <= 1'b0;
      code      <= '0;
    end else begin
      emit <= 1'b0;
      if (idle_cmd) begin
        state <= RX_IDLE;              // partial run is discarded
      end else if (tick) begin
        case (state)
          RX_IDLE: begin
            if (lvl_pulse) begin
              state     <= RX_CAPTURE;
              cur_pulse <= 1'b1;
              cnt       <= '0;
            end
          end
          RX_CAPTURE: begin
            if (lvl_pulse != cur_pulse) begin
              emit          <= 1'b1;
              code.is_space <= !cur_pulse;
              code.len_m1   <= cnt;
              cur_pulse     <= lvl_pulse;
              cnt           <= '0;
            end else if (cnt == CNT_TOP) begin
              // 128 ticks done: close this piece, this tick opens the next
              emit          <= 1'b1;
              code.is_space <= !cur_pulse;
              code.len_m1   <= cnt;
              cnt           <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ir_code_fifo.sv
module ir_code_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       drop
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          full;
  logic          pop_ok;
  logic          accept;

  assign full    = (cnt == CNT_FULL);
  assign pop_ok  = pop && (cnt != '0);
  assign accept  = push && (!full || pop_ok);
  assign drop    = push && full && !pop_ok;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({accept, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ir_rle_rx.sv
module ir_rle_rx
  import ir_rle_pkg::*;
#(
  parameter int unsigned PRESCALE  = 16,
  parameter int unsigned DIV_NORM  = 15,
  parameter int unsigned DIV_HIRES = 3,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned IRQ_LEVEL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              ir_invert,
  input  logic              fine_res,
  input  logic              idle_cmd,
  input  logic              stat_rd,
  output logic              code_valid,
  input  logic              code_ready,
  output logic [CODE_W-1:0] code_data,
  output logic              overrun,
  output logic              irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] IRQ_AT = CW'(IRQ_LEVEL);

  logic [1:0]    sync_q;
  logic          tick;
  logic          enc_emit;
  run_code_t     enc_code;
  logic [CW-1:0] fifo_cnt;
  logic          fifo_drop;
  logic          overrun_q;

  // Polarity is applied ahead of the synchronizer so reset reads as space.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ir_in ^ ir_invert};
  end

  ir_tick_gen #(
    .PRESCALE (PRESCALE),
    .DIV_NORM (DIV_NORM),
    .DIV_HIRES(DIV_HIRES)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .fine_res(fine_res),
    .tick    (tick)
  );

  ir_run_encoder u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .lvl_pulse(sync_q[1]),
    .idle_cmd (idle_cmd),
    .emit     (enc_emit),
    .code     (enc_code)
  );

  ir_code_fifo #(
    .DEPTH(DEPTH),
    .W    (CODE_W)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (enc_emit),
    .push_data(enc_code),
    .pop      (code_valid && code_ready),
    .rd_data  (code_data),
    .cnt      (fifo_cnt),
    .drop     (fifo_drop)
  );

  // A drop in the same cycle as a status read keeps the flag set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overrun_q <= 1'b0;
    else if (fifo_drop) overrun_q <= 1'b1;
    else if (stat_rd)   overrun_q <= 1'b0;
  end

  assign overrun    = overrun_q;
  assign code_valid = (fifo_cnt != '0);
  assign irq        = (fifo_cnt >= IRQ_AT);
endmodule

// File: rtl/ir_rle_rx_chk.sv
module ir_rle_rx_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          code_valid,
  input logic          code_ready,
  input logic [7:0]    code_data,
  input logic          overrun,
  input logic          irq,
  input logic          stat_rd,
  input logic [CW-1:0] fifo_cnt,
  input logic          fifo_drop
);
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid && !code_ready |=> code_valid && $stable(code_data));

  a_r5_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> code_valid);

  a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  a_r7_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |-> fifo_cnt == CW'(DEPTH));

  a_r7_drop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |=> overrun);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !stat_rd |=> overrun);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !fifo_drop |=> !overrun);
endmodule

bind ir_rle_rx ir_rle_rx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .code_valid(code_valid),
  .code_ready(code_ready),
  .code_data (code_data),
  .overrun   (overrun),
  .irq       (irq),
  .stat_rd   (stat_rd),
  .fifo_cnt  (fifo_cnt),
  .fifo_drop (fifo_drop)
);

// File: tb/ir_rle_rx_tb.sv
module ir_rle_rx_tb;
  localparam int PRE = 2;
  localparam int T_N = PRE * 15;
  localparam int T_H = PRE * 3;

  typedef struct packed {
    logic       fine;
    logic       inv;
    logic [8:0] p1;
    logic [8:0] s1;
    logic [8:0] p2;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 9'd3,   9'd5,   9'd2},
    '{1'b1, 1'b0, 9'd1,   9'd1,   9'd1},
    '{1'b0, 1'b1, 9'd4,   9'd2,   9'd7},
    '{1'b1, 1'b1, 9'd10,  9'd3,   9'd20},
    '{1'b1, 1'b0, 9'd128, 9'd1,   9'd2},
    '{1'b0, 1'b0, 9'd2,   9'd128, 9'd1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_in = 1'b0;
  logic       ir_invert = 1'b0;
  logic       fine_res = 1'b0;
  logic       idle_cmd = 1'b0;
  logic       stat_rd = 1'b0;
  logic       code_ready = 1'b0;
  logic       code_valid;
  logic [7:0] code_data;
  logic       overrun;
  logic       irq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ir_rle_rx #(.PRESCALE(PRE)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_in     (ir_in),
    .ir_invert (ir_invert),
    .fine_res  (fine_res),
    .idle_cmd  (idle_cmd),
    .stat_rd   (stat_rd),
    .code_valid(code_valid),
    .code_ready(code_ready),
    .code_data (code_data),
    .overrun   (overrun),
    .irq       (irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic pulse, input int ticks, input int per);
    @(negedge clk);
    ir_in = pulse ^ ir_invert;
    repeat (ticks * per - 1) @(negedge clk);
  endtask

  task automatic idle_hold();
    @(negedge clk);
    idle_cmd = 1'b1;
    ir_in    = ir_invert;
    repeat (6) @(negedge clk);
    idle_cmd = 1'b0;
  endtask

  task automatic setup(input logic fine, input logic inv);
    @(negedge clk);
    fine_res  = fine;
    ir_invert = inv;
    ir_in     = inv;
    idle_hold();
    repeat (4 * T_N) @(negedge clk);
  endtask

  // Returns {timeout, code}; a timeout never matches an expected code.
  task automatic read_code(output logic [8:0] r);
    int waited;
    waited = 0;
    while (!code_valid && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    if (!code_valid) begin
      r = 9'h1FF;
    end else begin
      r = {1'b0, code_data};
      code_ready = 1'b1;
      @(negedge clk);
      code_ready = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [8:0] r;
    logic [7:0] e;
    int seen;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "valid after reset", 16'(code_valid), 16'd0);
    chk("R9", "irq after reset", 16'(irq), 16'd0);
    chk("R9", "overrun after reset", 16'(overrun), 16'd0);

    // Table walk: R1 format, R2 tick per mode, R3 polarity, R6 128 boundary
    for (int v = 0; v < NV; v++) begin
      vec_t cv;
      int per;
      cv  = VECS[v];
      per = cv.fine ? T_H : T_N;
      setup(cv.fine, cv.inv);
      drive(1'b1, int'(cv.p1), per);
      drive(1'b0, int'(cv.s1), per);
      drive(1'b1, int'(cv.p2), per);
      drive(1'b0, 10, per);
      idle_hold();
      read_code(r);
      e = {1'b0, 7'(cv.p1 - 9'd1)};
      chk("R1 R2 R3", $sformatf("vec%0d pulse1", v), 16'(r), 16'(e));
      read_code(r);
      e = {1'b1, 7'(cv.s1 - 9'd1)};
      chk("R1 R2 R3", $sformatf("vec%0d space", v), 16'(r), 16'(e));
      read_code(r);
      e = {1'b0, 7'(cv.p2 - 9'd1)};
      chk("R1 R2 R3", $sformatf("vec%0d pulse2", v), 16'(r), 16'(e));
      chk("R8", $sformatf("vec%0d no code after idle", v), 16'(code_valid), 16'd0);
    end

    // R6: a 300-tick pulse splits into 128 + 128 + 44
    setup(1'b1, 1'b0);
    drive(1'b1, 300, T_H);
    drive(1'b0, 2, T_H);
    drive(1'b1, 1, T_H);
    drive(1'b0, 5, T_H);
    idle_hold();
    read_code(r); chk("R6", "split piece 1", 16'(r), 16'h7F);
    read_code(r); chk("R6", "split piece 2", 16'(r), 16'h7F);
    read_code(r); chk("R6", "split remainder", 16'(r), 16'h2B);
    read_code(r); chk("R6", "space after split", 16'(r), 16'h81);
    read_code(r); chk("R6", "pulse after split", 16'(r), 16'h00);
    chk("R6", "queue empty", 16'(code_valid), 16'd0);

    // R8: idle discards the open run, ignores spaces, resumes on pulse
    setup(1'b1, 1'b0);
    drive(1'b1, 3, T_H);
    drive(1'b0, 2, T_H);
    drive(1'b1, 4, T_H);
    idle_hold();
    read_code(r); chk("R8", "closed pulse", 16'(r), 16'h02);
    read_code(r); chk("R8", "closed space", 16'(r), 16'h81);
    chk("R8", "open pulse discarded", 16'(code_valid), 16'd0);
    drive(1'b0, 100, T_H);
    chk("R8", "space while idle", 16'(code_valid), 16'd0);
    drive(1'b1, 2, T_H);
    drive(1'b0, 3, T_H);
    idle_hold();
    read_code(r); chk("R8", "resumed pulse", 16'(r), 16'h01);
    chk("R8", "open space discarded", 16'(code_valid), 16'd0);

    // R5 / R7 / R4: fill past capacity with the consumer stalled
    setup(1'b1, 1'b0);
    for (int k = 0; k < 7; k++) drive((k % 2) == 0, 1, T_H);
    drive(1'b0, 4, T_H);
    chk("R5", "irq with 7 codes", 16'(irq), 16'd0);
    chk("R4", "valid with 7 codes", 16'(code_valid), 16'd1);
    drive(1'b1, 3, T_H);
    chk("R5", "irq with 8 codes", 16'(irq), 16'd1);
    for (int k = 0; k < 10; k++) drive((k % 2) == 1, (k == 9) ? 5 : 1, T_H);
    chk("R7", "overrun after drops", 16'(overrun), 16'd1);
    chk("R4", "head held while stalled", 16'(code_data), 16'h00);

    // R7: status read held across further drops; the set must win
    stat_rd = 1'b1;
    repeat (3) @(negedge clk);
    seen = 0;
    for (int k = 0; k < 3; k++) begin
      ir_in = logic'(k % 2) ^ ir_invert;
      repeat (T_H) begin
        @(negedge clk);
        if (overrun) seen++;
      end
    end
    chk("R7", "drop beats status read", 16'(seen > 0), 16'd1);
    stat_rd = 1'b0;
    repeat (2 * T_H) @(negedge clk);
    chk("R7", "overrun sticky", 16'(overrun), 16'd1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk("R7", "status read clears", 16'(overrun), 16'd0);
    for (int i = 0; i < 16; i++) begin
      if (i == 7)      e = 8'h83;
      else if (i == 8) e = 8'h02;
      else             e = (i % 2 == 1) ? 8'h80 : 8'h00;
      read_code(r);
      chk("R4 R5", $sformatf("queued code %0d", i), 16'(r), 16'(e));
    end
    chk("R5", "empty after drain", 16'(code_valid), 16'd0);
    chk("R5", "irq after drain", 16'(irq), 16'd0);
    idle_hold();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule